// File: doc/BRIEF.md
# Mode-Controlled GPIO Port

This block runs a small bank of general-purpose pins. Each pin has a 2-bit mode field, and that field picks one of four behaviours. In the first, a peripheral controls the pin. In the second, the pin drives a value from a data register. In the other two the pin is an input, with or without a weak pull-up. Software reaches the data register and the mode register through a plain synchronous read/write bus, using one select bit to choose between them.

Reading the data register returns a mix of sources. A pin in an input mode shows its synchronized pad level. Every other pin shows the stored register bit. A write always lands in the data register, but the value only reaches a pad whose pin is in output mode.

There are two reset inputs. A power-on reset clears everything. A manual reset returns every pin to peripheral control but keeps the stored data. Pad outputs, pull-up enables and the levels passed to the peripheral are all registered.

Top module: `gpio_mode_port`

## Requirements
- R1: Mode field codes: 00 peripheral, 01 output, 10 input with pull-up, 11 input without pull-up. Pin n uses bits [2n+1:2n] of the mode register, and the mode register reads back what was written. `pad_pu[n]` is high only in code 10. `pad_pu` and `pad_oe` are never high together.
- R2: In code 01, `pad_oe[n]`=1 and `pad_out[n]` equals data bit n.
- R3: In code 00, `pad_oe[n]`/`pad_out[n]` follow `per_oe[n]`/`per_out[n]`, and `per_in[n]` carries the synchronized pad level. In any other code `per_in[n]`=0.
- R4: In codes 10 and 11, `pad_oe[n]`=0 and `pad_out[n]`=0.
- R5: A data read (`bus_sel`=0) returns, for each bit, the synchronized pad level when the pin is in code 10 or 11. Otherwise it returns the stored bit. Read data appears on `bus_rdata` after the edge that samples `bus_rd`.
- R6: A data write (`bus_sel`=0) updates all stored bits whatever their modes. In an input mode the write leaves the pad and the read value unchanged, and the stored value shows once the pin is switched to output.
- R7: Power-on reset clears the data register to 0x00 and the mode register to all zeros, and drives every pad output low.
- R8: Manual reset sets the mode register to all zeros and keeps the data register's contents.
- R9: Pad levels pass through two flops. A change becomes visible to a read sampled on the third rising edge after the change.
- R10: Outputs are registered. A mode or data write shows on the pad outputs one edge after the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| man_rst | input | 1 | Synchronous manual reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | 0 selects the data register, 1 selects the mode register |
| bus_wdata | input | 2*NPINS | Write data (data register uses low NPINS bits) |
| bus_rdata | output | 2*NPINS | Registered read data |
| pad_in | input | NPINS | Pad input levels |
| pad_oe | output | NPINS | Pad output enables |
| pad_out | output | NPINS | Pad output values |
| pad_pu | output | NPINS | Pull-up enables |
| per_oe | input | NPINS | Peripheral output-enable request |
| per_out | input | NPINS | Peripheral output value |
| per_in | output | NPINS | Synchronized pad level to the peripheral |

## Verification
The bench targets the read-back source in every mode. If the source were taken from the wrong place, a read would return stored data where the pad level belongs, or the reverse. It writes data while pins are inputs and checks that the pads stay quiet. It then switches those pins to output, which exposes a design that drops such writes or leaks them onto the pad. A manual reset with data held would catch a design that clears the data register on the wrong reset. Three back-to-back reads across a pad change catch a synchronizer that is too short or too long.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    MODE_PERIPH = 2'b00,
    MODE_OUTPUT = 2'b01,
    MODE_IN_PU  = 2'b10,
    MODE_IN_NPU = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_port_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       stored,
  input  logic       level,
  input  logic       p_oe,
  input  logic       p_out,
  output logic       oe,
  output logic       out,
  output logic       pu,
  output logic       to_per,
  output logic       rd_bit
);
  always_comb begin
    oe     = 1'b0;
    out    = 1'b0;
    pu     = 1'b0;
    to_per = 1'b0;
    rd_bit = stored;
    case (pin_mode_e'(mode))
      MODE_PERIPH: begin
        oe     = p_oe;
        out    = p_out;
        to_per = level;
      end
      MODE_OUTPUT: begin
        oe  = 1'b1;
        out = stored;
      end
      MODE_IN_PU: begin
        pu     = 1'b1;
        rd_bit = level;
      end
      default: rd_bit = level;
    endcase
  end
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port #(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_rst,
  input  logic               man_rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_sel,
  input  logic [2*NPINS-1:0] bus_wdata,
  output logic [2*NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_pu,
  input  logic [NPINS-1:0]   per_oe,
  input  logic [NPINS-1:0]   per_out,
  output logic [NPINS-1:0]   per_in
);
  localparam int MW = 2 * NPINS;

  logic [NPINS-1:0] data_q;
  logic [MW-1:0]    mode_q;
  logic [NPINS-1:0] lvl_s;
  logic [NPINS-1:0] oe_c, out_c, pu_c, per_c, rd_c;
  logic             any_rst;

  assign any_rst = por_rst | man_rst;

  // data register: only power-on reset clears it
  always_ff @(posedge clk) begin
    if (por_rst)                data_q <= '0;
    else if (bus_wr && !bus_sel) data_q <= bus_wdata[NPINS-1:0];
  end

  // mode register: either reset returns all pins to peripheral control
  always_ff @(posedge clk) begin
    if (any_rst)                mode_q <= '0;
    else if (bus_wr && bus_sel) mode_q <= bus_wdata;
  end

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (any_rst),
    .d   (pad_in),
    .q   (lvl_s)
  );

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      gpio_pin_cell u_cell (
        .mode   (mode_q[2*i+1:2*i]),
        .stored (data_q[i]),
        .level  (lvl_s[i]),
        .p_oe   (per_oe[i]),
        .p_out  (per_out[i]),
        .oe     (oe_c[i]),
        .out    (out_c[i]),
        .pu     (pu_c[i]),
        .to_per (per_c[i]),
        .rd_bit (rd_c[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (any_rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
      pad_pu  <= '0;
      per_in  <= '0;
    end else begin
      pad_oe  <= oe_c;
      pad_out <= out_c;
      pad_pu  <= pu_c;
      per_in  <= per_c;
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst)      bus_rdata <= '0;
    else if (bus_rd)  bus_rdata <= bus_sel ? mode_q : {{(MW-NPINS){1'b0}}, rd_c};
  end
endmodule

// File: rtl/gpio_mode_port_chk.sv
module gpio_mode_port_chk #(
  parameter int NPINS = 8
) (
  input logic               clk,
  input logic               por_rst,
  input logic               man_rst,
  input logic               bus_wr,
  input logic               bus_sel,
  input logic [NPINS-1:0]   data_q,
  input logic [2*NPINS-1:0] mode_q,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   pad_out,
  input logic [NPINS-1:0]   pad_pu
);
  assert_pu_oe_excl_R1: assert property (@(posedge clk) disable iff (por_rst)
    (pad_pu & pad_oe) == '0);

  assert_por_clear_R7: assert property (@(posedge clk)
    por_rst |=> (data_q == '0 && mode_q == '0));

  assert_man_keep_R8: assert property (@(posedge clk) disable iff (por_rst)
    (man_rst && !(bus_wr && !bus_sel)) |=> $stable(data_q));

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin_chk
      assert_input_quiet_R4: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        mode_q[2*i+1] |=> (!pad_oe[i] && !pad_out[i]));

      assert_out_drive_R2: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        (mode_q[2*i+1:2*i] == 2'b01) |=> (pad_oe[i] && pad_out[i] == $past(data_q[i])));
    end
  endgenerate
endmodule

bind gpio_mode_port gpio_mode_port_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .por_rst (por_rst),
  .man_rst (man_rst),
  .bus_wr  (bus_wr),
  .bus_sel (bus_sel),
  .data_q  (data_q),
  .mode_q  (mode_q),
  .pad_oe  (pad_oe),
  .pad_out (pad_out),
  .pad_pu  (pad_pu)
);

// File: tb/gpio_mode_port_tb.sv
module gpio_mode_port_tb;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          por_rst = 1'b1, man_rst = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [2*N-1:0] bus_wdata = '0;
  logic [2*N-1:0] bus_rdata;
  logic [N-1:0]  pad_in = '0, per_oe = '0, per_out = '0;
  logic [N-1:0]  pad_oe, pad_out, pad_pu, per_in;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_mode_port #(.NPINS(N)) u_dut (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .per_oe(per_oe), .per_out(per_out), .per_in(per_in)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] val);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = val;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [15:0] val);
    bus_rd = 1'b1; bus_sel = sel;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    val = bus_rdata;
  endtask

  task automatic pulse_por();
    @(negedge clk); por_rst = 1'b1;
    settle();
    por_rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    pulse_por();
    check("R7 pad_oe after por", 16'(pad_oe), 16'h0);
    check("R7 pad_out after por", 16'(pad_out), 16'h0);
    check("R7 pad_pu after por", 16'(pad_pu), 16'h0);
    reg_read(1'b1, v); check("R7 mode after por", v, 16'h0);
    reg_read(1'b0, v); check("R7 data after por", v, 16'h0);
  endtask

  task automatic t_output();
    logic [15:0] v;
    reg_write(1'b1, 16'h5555);
    reg_write(1'b0, 16'h00A5);
    settle();
    check("R2 pad_oe output", 16'(pad_oe), 16'h00FF);
    check("R2 pad_out output", 16'(pad_out), 16'h00A5);
    check("R1 pad_pu output", 16'(pad_pu), 16'h0);
    reg_read(1'b0, v); check("R5 read stored in output", v, 16'h00A5);
    reg_read(1'b1, v); check("R1 mode readback", v, 16'h5555);
  endtask

  task automatic t_latency();
    // R10: write taken at edge A, pad update at edge B
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 16'h00C3;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    check("R10 pad_out unchanged one edge", 16'(pad_out), 16'h00A5);
    settle();
    check("R10 pad_out after two edges", 16'(pad_out), 16'h00C3);
  endtask

  task automatic t_inputs();
    logic [15:0] v;
    pad_in = 8'h3C;
    reg_write(1'b1, 16'hFFAA);
    settle(); settle();
    check("R4 pad_oe input", 16'(pad_oe), 16'h0);
    check("R4 pad_out input", 16'(pad_out), 16'h0);
    check("R1 pad_pu only code 10", 16'(pad_pu), 16'h000F);
    reg_read(1'b0, v); check("R5 read pad in input", v, 16'h003C);
    reg_write(1'b0, 16'h005A);
    settle();
    check("R6 pad_oe after input write", 16'(pad_oe), 16'h0);
    reg_read(1'b0, v); check("R6 read after input write", v, 16'h003C);
    reg_write(1'b1, 16'h5555);
    settle();
    check("R6 stored shows in output", 16'(pad_out), 16'h005A);
  endtask

  task automatic t_periph();
    logic [15:0] v;
    per_oe = 8'h0F; per_out = 8'h33; pad_in = 8'hC3;
    reg_write(1'b1, 16'h0000);
    settle(); settle(); settle();
    check("R3 pad_oe periph", 16'(pad_oe), 16'h000F);
    check("R3 pad_out periph", 16'(pad_out), 16'h0033);
    check("R3 per_in periph", 16'(per_in), 16'h00C3);
    reg_read(1'b0, v); check("R5 read stored in periph", v, 16'h005A);
    per_oe = '0; per_out = '0;
  endtask

  task automatic t_mixed();
    logic [15:0] v;
    pad_in = 8'h00;
    reg_write(1'b0, 16'h00FF);
    reg_write(1'b1, 16'hE4E4);
    settle(); settle();
    check("R2 mixed pad_oe", 16'(pad_oe), 16'h0022);
    check("R2 mixed pad_out", 16'(pad_out), 16'h0022);
    check("R1 mixed pad_pu", 16'(pad_pu), 16'h0044);
    check("R3 mixed per_in", 16'(per_in), 16'h0000);
    reg_read(1'b0, v); check("R5 mixed read", v, 16'h0033);
    pad_in = 8'hFF;
    settle(); settle(); settle();
    check("R3 per_in only periph pins", 16'(per_in), 16'h0011);
  endtask

  task automatic t_manual();
    logic [15:0] v;
    reg_write(1'b1, 16'h5555);
    reg_write(1'b0, 16'h0096);
    @(negedge clk); man_rst = 1'b1;
    settle();
    man_rst = 1'b0;
    reg_read(1'b1, v); check("R8 mode cleared by manual", v, 16'h0);
    reg_read(1'b0, v); check("R8 data kept by manual", v, 16'h0096);
    check("R8 pad_oe after manual", 16'(pad_oe), 16'h0);
    pulse_por();
    reg_read(1'b0, v); check("R7 data cleared by por", v, 16'h0);
  endtask

  task automatic t_sync();
    logic [15:0] v1, v2, v3;
    pad_in = 8'h00;
    reg_write(1'b1, 16'hFFFF);
    settle(); settle(); settle();
    pad_in = 8'hFF;
    reg_read(1'b0, v1);
    reg_read(1'b0, v2);
    reg_read(1'b0, v3);
    check("R9 first edge", v1, 16'h0000);
    check("R9 second edge", v2, 16'h0000);
    check("R9 third edge", v3, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_rst = 1'b0;
    t_reset();
    t_output();
    t_latency();
    t_inputs();
    t_periph();
    t_mixed();
    t_manual();
    t_sync();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule